// File: doc/BRIEF.md
# Permission-Checking Page Translation Buffer

This block turns 64-bit virtual byte addresses from one process into physical addresses using 4 KB pages. It holds a small fully associative set of recently used page translations. Each lookup also carries an access kind (instruction fetch, data read or data write) and is checked against the permission flags stored with the page. A lookup finishes in one cycle and returns one of three things: the physical address, a miss, or a fault code.

When a lookup misses, the block stops accepting requests. It waits for the surrounding walker to present the 64-bit page table entry for the missing page on the refill port. The block decodes that entry and installs it if the page is resident. It then answers the stalled access as if it had hit. Only the lower, user half of the address space is translated. Any address with a nonzero bit among bits 63..47 is rejected at once and no lookup is made.

Top module: `xlat_guard_tlb`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and no translation is held, so the first lookup of any user page returns code 1 (miss).
- R2: Each accepted request (`req_valid` and `req_ready` high at a clock edge) gives exactly one `rsp_valid` pulse at that edge. `fill_valid` has no effect while the block is not waiting on a miss.
- R3: A request with any of address bits 63..47 set returns code 2 (bad address) with `rsp_paddr` 0, leaves `req_ready` at 1 and installs nothing.
- R4: A user lookup that finds no matching page returns code 1 with `rsp_paddr` 0. `req_ready` then stays 0 until a refill is accepted.
- R5: A refill entry of all zeros answers the stalled access with code 3 (no such page) and installs nothing.
- R6: A nonzero refill entry with bit 0 clear answers with code 4 (page not resident) and installs nothing.
- R7: A refill entry with bit 0 set is installed for the stalled page. Its frame number is bits 51..12, its write flag is bit 1 and its execute-disable flag is bit 63. The stalled access is then answered with the same code and address a hit would give.
- R8: A hit returns code 0 and `rsp_paddr` = {40-bit frame number, virtual address bits 11..0}. The virtual page number used as tag is address bits 46..12.
- R9: Access kind encoding is 0 = fetch, 1 = read, 2 = write, 3 = read. A write to a page whose write flag is 0 returns code 5. A fetch from a page whose execute-disable flag is 1 returns code 6. Reads of resident pages never fault. Every fault has `rsp_paddr` 0.
- R10: An install goes to the lowest-numbered free entry. When all entries are full it replaces entries in round-robin order, starting at entry 0 and moving on one place per replacement.
- R11: A one-cycle `flush` pulse removes every held translation, so every later lookup misses until it is refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Drop all held translations |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup (low while waiting on a refill) |
| req_vaddr | input | 64 | Virtual byte address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 read |
| fill_valid | input | 1 | Refill entry present |
| fill_pte | input | 64 | Page table entry for the stalled page |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_code | output | 3 | 0 ok, 1 miss, 2 bad address, 3 no page, 4 not resident, 5 write protect, 6 execute fault |
| rsp_paddr | output | 52 | Physical address on code 0, otherwise 0 |

## Verification
Some properties are checked by assertions on every cycle:
- at most one entry matches any tag;
- a flush empties the entry set in one cycle;
- a free entry is always chosen before an occupied one;
- every accepted request or refill gives exactly one response pulse;
- out-of-range addresses and all-zero entries give their fault codes;
- reads never fault;
- a successful translation keeps the page offset.

Other behaviour needs the bench's scenarios to show it. The bench checks the frame number that comes back from a refill, and how write protection and execute-disable interact per access kind. It checks that absent or non-resident entries are not cached, that an idle refill pulse changes nothing, and the exact round-robin eviction order once the set is full.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int VA_W    = 64;
  parameter int OFF_W   = 12;
  parameter int VPN_W   = 35;
  parameter int PPN_W   = 40;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int VPN_HI = OFF_W + VPN_W - 1;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_MISS    = 3'd1,
    RC_BADADDR = 3'd2,
    RC_NOPAGE  = 3'd3,
    RC_ABSENT  = 3'd4,
    RC_WPROT   = 3'd5,
    RC_XFAULT  = 3'd6
  } rsp_code_e;

  typedef enum logic [1:0] {
    AK_FETCH = 2'd0,
    AK_READ  = 2'd1,
    AK_WRITE = 2'd2,
    AK_READ2 = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic             wr;
    logic             xd;
    logic [PPN_W-1:0] ppn;
  } page_attr_t;
endpackage

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       wr_ok,
  input  logic       no_exec,
  output rsp_code_e  code
);
  always_comb begin
    code = RC_OK;
    if (kind == AK_WRITE && !wr_ok) begin
      code = RC_WPROT;
    end else if (kind == AK_FETCH && no_exec) begin
      code = RC_XFAULT;
    end
  end
endmodule

// File: rtl/xlat_entry_cam.sv
module xlat_entry_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [VPN_W-1:0]  lk_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_tag,
  input  page_attr_t        wr_attr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output page_attr_t        hit_attr,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENTRIES-1:0] hit_vec;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  page_attr_t         attr_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel        = wr_en && (wr_idx == IDX_W'(g));
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);

    always_comb begin
      valid_d[g] = valid_q[g];
      if (flush)    valid_d[g] = 1'b0;
      else if (sel) valid_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[g] <= 1'b0;
      else        valid_q[g] <= valid_d[g];
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g]  <= wr_tag;
        attr_q[g] <= wr_attr;
      end
    end
  end

  always_comb begin
    hit_idx  = '0;
    hit_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_idx  = IDX_W'(i);
        hit_attr = attr_q[i];
      end
    end
  end

  assign hit       = |hit_vec;
  assign valid_vec = valid_q;

  // R8: a tag never matches two entries
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R11: flush empties the set in one cycle
  a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               alloc,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic             rr_en;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;
  assign rr_en  = alloc && !any_free;

  always_comb begin
    rr_d = rr_q;
    if (rr_en) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R10: a free entry is always preferred over an occupied one
  a_r10_prefer_free: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec != '1) |-> !valid_vec[victim]);
endmodule

// File: rtl/xlat_guard_tlb.sv
module xlat_guard_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [1:0]          req_kind,
  input  logic                fill_valid,
  input  logic [63:0]         fill_pte,
  output logic                rsp_valid,
  output logic [2:0]          rsp_code,
  output logic [PA_W-1:0]     rsp_paddr
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e             state_q, state_d;
  logic [VPN_W-1:0]   pend_vpn_q;
  logic [OFF_W-1:0]   pend_off_q;
  logic [1:0]         pend_kind_q;
  logic               pend_en;
  logic               rsp_valid_q, rsp_valid_d;
  rsp_code_e          rsp_code_q, rsp_code_d;
  logic [PA_W-1:0]    rsp_paddr_q, rsp_paddr_d;
  logic               rsp_en;

  logic               req_fire, fill_fire, user_ok;
  logic [VPN_W-1:0]   lk_tag;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx, victim;
  page_attr_t         hit_attr, new_attr;
  logic [ENTRIES-1:0] valid_vec;
  logic               wr_en, alloc;
  logic [IDX_W-1:0]   wr_idx;
  rsp_code_e          hit_code, fill_code;
  logic               unused_pte_bits;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign fill_fire = fill_valid && (state_q == ST_WAIT);
  assign user_ok   = (req_vaddr[VA_W-1:VPN_HI+1] == '0);
  assign lk_tag    = (state_q == ST_WAIT) ? pend_vpn_q : req_vaddr[VPN_HI:OFF_W];

  assign new_attr.wr  = fill_pte[1];
  assign new_attr.xd  = fill_pte[63];
  assign new_attr.ppn = fill_pte[PA_W-1:OFF_W];
  assign unused_pte_bits = ^{fill_pte[62:PA_W], fill_pte[OFF_W-1:2]};

  xlat_entry_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_tag   (lk_tag),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (pend_vpn_q),
    .wr_attr  (new_attr),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .hit_attr (hit_attr),
    .valid_vec(valid_vec)
  );

  xlat_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_vec(valid_vec),
    .alloc    (alloc),
    .victim   (victim)
  );

  xlat_perm_check u_chk_hit (
    .kind   (req_kind),
    .wr_ok  (hit_attr.wr),
    .no_exec(hit_attr.xd),
    .code   (hit_code)
  );

  xlat_perm_check u_chk_fill (
    .kind   (pend_kind_q),
    .wr_ok  (new_attr.wr),
    .no_exec(new_attr.xd),
    .code   (fill_code)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    pend_en     = 1'b0;
    rsp_valid_d = 1'b0;
    rsp_en      = 1'b0;
    rsp_code_d  = rsp_code_q;
    rsp_paddr_d = rsp_paddr_q;
    wr_en       = 1'b0;
    alloc       = 1'b0;
    wr_idx      = hit ? hit_idx : victim;
    if (req_fire) begin
      rsp_valid_d = 1'b1;
      rsp_en      = 1'b1;
      rsp_paddr_d = '0;
      if (!user_ok) begin
        rsp_code_d = RC_BADADDR;
      end else if (hit) begin
        rsp_code_d = hit_code;
        if (hit_code == RC_OK) rsp_paddr_d = {hit_attr.ppn, req_vaddr[OFF_W-1:0]};
      end else begin
        rsp_code_d = RC_MISS;
        pend_en    = 1'b1;
        state_d    = ST_WAIT;
      end
    end else if (fill_fire) begin
      rsp_valid_d = 1'b1;
      rsp_en      = 1'b1;
      rsp_paddr_d = '0;
      state_d     = ST_IDLE;
      if (fill_pte == '0) begin
        rsp_code_d = RC_NOPAGE;
      end else if (!fill_pte[0]) begin
        rsp_code_d = RC_ABSENT;
      end else begin
        wr_en      = 1'b1;
        alloc      = !hit;
        rsp_code_d = fill_code;
        if (fill_code == RC_OK) rsp_paddr_d = {new_attr.ppn, pend_off_q};
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RC_OK;
      rsp_paddr_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      if (rsp_en) begin
        rsp_code_q  <= rsp_code_d;
        rsp_paddr_q <= rsp_paddr_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pend_en) begin
      pend_vpn_q  <= req_vaddr[VPN_HI:OFF_W];
      pend_off_q  <= req_vaddr[OFF_W-1:0];
      pend_kind_q <= req_kind;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_paddr = rsp_paddr_q;

  // R2: an accepted request is answered at the next edge
  a_r2_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2: no pulse without a request or a waited-for refill
  a_r2_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !(fill_valid && !req_ready)) |=> !rsp_valid);

  // R3: out-of-range address faults and does not stall
  a_r3_bad_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_vaddr[63:47] != '0))
      |=> (rsp_code == RC_BADADDR && req_ready && rsp_paddr == '0));

  // R4: a miss leaves the block waiting
  a_r4_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RC_MISS) |-> !req_ready);

  // R5: all-zero entry means no page
  a_r5_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !req_ready && fill_pte == '0) |=> (rsp_code == RC_NOPAGE));

  // R8: a successful translation keeps the page offset
  a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready)
      |=> (rsp_code != RC_OK || rsp_paddr[11:0] == $past(req_vaddr[11:0])));

  // R9: reads never fault on a resident page
  a_r9_read_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_vaddr[63:47] == '0 && req_kind[0])
      |=> (rsp_code == RC_OK || rsp_code == RC_MISS));
endmodule

// File: tb/xlat_guard_tlb_test.sv
`timescale 1ns/1ps
module xlat_guard_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        fill_valid;
  logic [63:0] fill_pte;
  logic        rsp_valid;
  logic [2:0]  rsp_code;
  logic [51:0] rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [1:0] K_F = 2'd0, K_R = 2'd1, K_W = 2'd2, K_R3 = 2'd3;

  always #2.5 clk = ~clk;

  xlat_guard_tlb uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind),
    .fill_valid(fill_valid), .fill_pte(fill_pte),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
  );

  function automatic logic [63:0] va(input logic [34:0] vpn, input logic [11:0] off);
    return {17'b0, vpn, off};
  endfunction

  function automatic logic [63:0] pte(input logic [39:0] ppn, input logic w, input logic xd);
    return {xd, 11'b0, ppn, 10'b0, w, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_req(input string req, input logic [63:0] a, input logic [1:0] k,
                        input logic [2:0] ecode, input logic [51:0] epa);
    @(negedge clk);
    chk({req, " ready"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = a; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " code"},  64'(rsp_code),  64'(ecode));
    chk({req, " paddr"}, 64'(rsp_paddr), 64'(epa));
  endtask

  task automatic do_fill(input string req, input logic [63:0] p,
                         input logic [2:0] ecode, input logic [51:0] epa);
    @(negedge clk);
    chk({req, " stalled"}, 64'(req_ready), 64'd0);
    fill_valid = 1'b1; fill_pte = p;
    @(negedge clk);
    fill_valid = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " code"},  64'(rsp_code),  64'(ecode));
    chk({req, " paddr"}, 64'(rsp_paddr), 64'(epa));
    chk({req, " ready"}, 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_idle_fill;
    // R2: fill while idle is ignored
    @(negedge clk);
    fill_valid = 1'b1; fill_pte = pte(40'h1, 1'b1, 1'b0);
    @(negedge clk);
    fill_valid = 1'b0;
    chk("R2 idle fill no pulse", 64'(rsp_valid), 64'd0);
    do_req("R1 first lookup misses", va(35'h12345, 12'h010), K_R, 3'd1, 52'd0);
    chk("R4 stall after miss", 64'(req_ready), 64'd0);
    do_fill("R7 fill A", pte(40'hABCDE, 1'b1, 1'b0), 3'd0, {40'hABCDE, 12'h010});
  endtask

  task automatic t_hits;
    do_req("R8 read hit",   va(35'h12345, 12'hFFF), K_R,  3'd0, {40'hABCDE, 12'hFFF});
    do_req("R9 write hit",  va(35'h12345, 12'h000), K_W,  3'd0, {40'hABCDE, 12'h000});
    do_req("R9 fetch hit",  va(35'h12345, 12'h7A4), K_F,  3'd0, {40'hABCDE, 12'h7A4});
    do_req("R9 kind3 read", va(35'h12345, 12'h123), K_R3, 3'd0, {40'hABCDE, 12'h123});
  endtask

  task automatic t_perms;
    do_req("R4 miss B", va(35'h7_0000_0001, 12'h040), K_W, 3'd1, 52'd0);
    do_fill("R7 fill B write-protected", pte(40'hFF_0000_0001, 1'b0, 1'b1), 3'd5, 52'd0);
    do_req("R9 fetch xd",  va(35'h7_0000_0001, 12'h044), K_F, 3'd6, 52'd0);
    do_req("R9 write wp",  va(35'h7_0000_0001, 12'h048), K_W, 3'd5, 52'd0);
    do_req("R9 read ok",   va(35'h7_0000_0001, 12'h04C), K_R, 3'd0, {40'hFF_0000_0001, 12'h04C});
  endtask

  task automatic t_range;
    do_req("R3 just above user", 64'h0000_8000_0000_0000, K_R, 3'd2, 52'd0);
    do_req("R3 kernel base",     64'hFFFF_8000_0000_0000, K_R, 3'd2, 52'd0);
    do_req("R3 top bit only",    64'h8000_0000_0000_0000, K_F, 3'd2, 52'd0);
    do_req("R4 top user page",   64'h0000_7FFF_FFFF_FFFF, K_R, 3'd1, 52'd0);
    do_fill("R5 zero entry", 64'd0, 3'd3, 52'd0);
    do_req("R5 not installed", 64'h0000_7FFF_FFFF_F000, K_R, 3'd1, 52'd0);
    do_fill("R6 absent entry", 64'h0000_0000_0055_5000, 3'd4, 52'd0);
    do_req("R6 not installed", 64'h0000_7FFF_FFFF_F008, K_W, 3'd1, 52'd0);
    do_fill("R5 zero again", 64'd0, 3'd3, 52'd0);
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R11 flush no pulse", 64'(rsp_valid), 64'd0);
    do_req("R11 A gone", va(35'h12345, 12'h010), K_R, 3'd1, 52'd0);
    do_fill("R11 A refill", pte(40'h00042, 1'b1, 1'b0), 3'd0, {40'h00042, 12'h010});
    do_req("R11 B gone", va(35'h7_0000_0001, 12'h0), K_R, 3'd1, 52'd0);
    do_fill("R11 B none", 64'd0, 3'd3, 52'd0);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_replace;
    for (int i = 0; i < 8; i++) begin
      do_req("R10 fill miss", va(35'(32'h100 + i), 12'h0), K_R, 3'd1, 52'd0);
      do_fill("R10 fill", pte(40'(32'h500 + i), 1'b1, 1'b0), 3'd0, {40'(32'h500 + i), 12'h0});
    end
    for (int i = 0; i < 8; i++) begin
      do_req("R10 all held", va(35'(32'h100 + i), 12'h8), K_R, 3'd0, {40'(32'h500 + i), 12'h8});
    end
    do_req("R10 ninth miss", va(35'h200, 12'h0), K_R, 3'd1, 52'd0);
    do_fill("R10 ninth fill", pte(40'h900, 1'b1, 1'b0), 3'd0, {40'h900, 12'h0});
    do_req("R10 page1 kept", va(35'h101, 12'h0), K_R, 3'd0, {40'h501, 12'h0});
    do_req("R10 page0 evicted", va(35'h100, 12'h0), K_R, 3'd1, 52'd0);
    do_fill("R10 page0 back", pte(40'h600, 1'b1, 1'b0), 3'd0, {40'h600, 12'h0});
    do_req("R10 ninth kept", va(35'h200, 12'h4), K_R, 3'd0, {40'h900, 12'h4});
    do_req("R10 page2 kept", va(35'h102, 12'h0), K_R, 3'd0, {40'h502, 12'h0});
    do_req("R10 page1 evicted", va(35'h101, 12'h0), K_R, 3'd1, 52'd0);
    do_fill("R10 page1 none", 64'd0, 3'd3, 52'd0);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    req_kind = K_R; fill_valid = 1'b0; fill_pte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_idle_fill;
    t_hits;
    t_perms;
    t_range;
    t_flush;
    t_replace;
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule